// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock

This block keeps wall-clock time as a plain count of seconds. A slow tick enable at 32.768 kHz feeds a programmable prescaler that emits one pulse per second. Each pulse advances a 32-bit seconds register. A 32-bit alarm value is compared with that register whenever it changes. Two event flags (a once-per-second flag and an alarm flag) sit next to their interrupt enables in one status word. Each flag drives its own interrupt line.

Software reaches the block through a single-cycle register port. A write takes effect at the next clock edge. Reads are combinational from the address. The prescaler supports a slow correction: once every 1024 seconds, a programmed number of input ticks is removed from one second, so a crystal that runs fast can be pulled back.

Top module: `rtc_seconds_unit`

## Requirements
- R1: After synchronous reset, every register reads zero and both interrupt outputs are low.
- R2: The register offsets are: alarm at 0x00, seconds at 0x04, prescaler at 0x08 and status at 0x10. Any other offset reads zero. The prescaler word reads back the divisor in bits [15:0] and the correction count in bits [25:16], with all other bits zero. The status word places the second-interrupt enable in bit 3, the alarm-interrupt enable in bit 2, the second flag in bit 1 and the alarm flag in bit 0, with all other bits zero.
- R3: One second lasts divisor+1 clock cycles in which `tick_in` is high. Cycles with `tick_in` low do not advance the prescaler. A write to the prescaler register restarts both the divisor phase and the 1024-second correction cycle.
- R4: A divisor field of zero behaves as 32767, giving 32768 input ticks per second.
- R5: With a nonzero correction count C, the 1024th second after a prescaler write, and every 1024th second after that, lasts divisor+1-C input ticks. It never lasts less than one tick.
- R6: The seconds register increments by one at the end of each second and wraps from 0xFFFFFFFF to zero. A software write loads the written value, reads back, and wins over an increment in the same cycle.
- R7: The second flag (status bit 1) becomes set at the end of every second.
- R8: The alarm flag (status bit 0) becomes set when the seconds register takes a value equal to the alarm register, through either an increment or a write. A seconds value that stays unchanged does not set it again. Writing the alarm register alone never sets it.
- R9: Writing 1 to status bit 1 or bit 0 clears that flag, and writing 0 leaves it unchanged. Bits 3 and 2 take the written value. If an event and a clear fall in the same cycle, the flag ends up set.
- R10: `irq_tick` is high exactly when status bits 3 and 1 are both set. `irq_alarm` is high exactly when status bits 2 and 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | 32.768 kHz tick enable, one cycle wide per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_tick | output | 1 | Once-per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench sweeps small divisors and counts the seconds at the tick just before and just after each boundary. An off-by-one prescaler therefore shows up as a count that is early or late. It runs a full 1024-second correction cycle, with both a small correction and one that would overshoot. A design that applies the correction on the wrong second, or lets the limit underflow, reports the wrong count at 1023 or 1024. Collisions placed on an exact cycle (a write against an increment, and a flag clear against a second event) catch a design that picks the wrong priority. Repeated reads of an unchanged matching time, and rewrites of the alarm, catch a level-sensitive compare that would set the alarm flag again and again.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_DATA_W   = 32;
    localparam int RTC_ADDR_W   = 5;
    localparam int RTC_DIV_W    = 16;
    localparam int RTC_TRIM_W   = 10;
    localparam int RTC_SPAN_W   = 10;
    localparam int RTC_DEF_DIV  = 32767;

    typedef enum logic [RTC_ADDR_W-1:0] {
        OFS_ALARM   = 5'h00,
        OFS_SECONDS = 5'h04,
        OFS_PRESC   = 5'h08,
        OFS_STATUS  = 5'h10
    } rtc_ofs_e;

    // Bit order is the software-visible layout: [3] tick_en, [2] alarm_en,
    // [1] tick_flag, [0] alarm_flag.
    typedef struct packed {
        logic tick_en;
        logic alarm_en;
        logic tick_flag;
        logic alarm_flag;
    } rtc_status_t;

    // Next status: enables load on write, flags clear on written ones,
    // and an incoming event beats a clear in the same cycle.
    function automatic rtc_status_t status_next(
        input rtc_status_t cur,
        input logic        wr,
        input logic [3:0]  wd,
        input logic        tick_ev,
        input logic        alarm_ev
    );
        rtc_status_t n;
        n = cur;
        if (wr) begin
            n.tick_en    = wd[3];
            n.alarm_en   = wd[2];
            n.tick_flag  = cur.tick_flag  & ~wd[1];
            n.alarm_flag = cur.alarm_flag & ~wd[0];
        end
        if (tick_ev)  n.tick_flag  = 1'b1;
        if (alarm_ev) n.alarm_flag = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W   = 16,
    parameter int TRIM_W  = 10,
    parameter int SPAN_W  = 10,
    parameter int DEF_DIV = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [TRIM_W-1:0] trim_val,
    output logic              sec_tick
);
    logic [DIV_W-1:0]  phase;
    logic [SPAN_W-1:0] span;
    logic [DIV_W-1:0]  eff_div;
    logic [DIV_W-1:0]  trim_ext;
    logic [DIV_W-1:0]  limit;
    logic              corr_sec;
    logic              at_end;

    assign eff_div  = (div_val == '0) ? DIV_W'(DEF_DIV) : div_val;
    assign trim_ext = DIV_W'(trim_val);
    assign corr_sec = &span;

    always_comb begin
        limit = eff_div;
        if (corr_sec && trim_ext != '0) begin
            if (trim_ext > eff_div) limit = '0;
            else                    limit = eff_div - trim_ext;
        end
    end

    assign at_end   = (phase >= limit);
    assign sec_tick = tick_in && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
            span  <= '0;
        end else if (tick_in) begin
            if (at_end) begin
                phase <= '0;
                span  <= span + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              cnt_wr,
    input  logic              alarm_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] seconds,
    output logic [DATA_W-1:0] alarm_val,
    output logic              alarm_hit
);
    logic [DATA_W-1:0] nxt;
    logic              upd;

    assign upd       = cnt_wr || sec_tick;
    assign nxt       = cnt_wr ? wdata : seconds + 1'b1;
    assign alarm_hit = upd && (nxt == alarm_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            seconds   <= '0;
            alarm_val <= '0;
        end else begin
            if (upd)      seconds   <= nxt;
            if (alarm_wr) alarm_val <= wdata;
        end
    end
endmodule

// File: rtl/rtc_event_ctrl.sv
module rtc_event_ctrl
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        st_wr,
    input  logic [3:0]  st_wdata,
    input  logic        tick_ev,
    input  logic        alarm_ev,
    output rtc_status_t status,
    output logic        irq_tick,
    output logic        irq_alarm
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_next(status, st_wr, st_wdata, tick_ev, alarm_ev);
    end

    assign irq_tick  = status.tick_en  & status.tick_flag;
    assign irq_alarm = status.alarm_en & status.alarm_flag;
endmodule

// File: rtl/rtc_seconds_unit.sv
module rtc_seconds_unit
    import rtc_pkg::*;
#(
    parameter int DATA_W  = RTC_DATA_W,
    parameter int ADDR_W  = RTC_ADDR_W,
    parameter int DIV_W   = RTC_DIV_W,
    parameter int TRIM_W  = RTC_TRIM_W,
    parameter int SPAN_W  = RTC_SPAN_W,
    parameter int DEF_DIV = RTC_DEF_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_tick,
    output logic              irq_alarm
);
    localparam int TRIM_LSB = DIV_W;
    localparam int PRESC_W  = DIV_W + TRIM_W;

    logic              alarm_wr, cnt_wr, presc_wr, st_wr;
    logic              sec_tick, alarm_hit;
    logic [DATA_W-1:0] seconds, alarm_val;
    logic [DIV_W-1:0]  div_q;
    logic [TRIM_W-1:0] trim_q;
    rtc_status_t       status_q;

    assign alarm_wr = reg_wr && (reg_addr == ADDR_W'(OFS_ALARM));
    assign cnt_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_SECONDS));
    assign presc_wr = reg_wr && (reg_addr == ADDR_W'(OFS_PRESC));
    assign st_wr    = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            trim_q <= '0;
        end else if (presc_wr) begin
            div_q  <= reg_wdata[DIV_W-1:0];
            trim_q <= reg_wdata[TRIM_LSB +: TRIM_W];
        end
    end

    rtc_prescaler #(
        .DIV_W(DIV_W), .TRIM_W(TRIM_W), .SPAN_W(SPAN_W), .DEF_DIV(DEF_DIV)
    ) u_presc (
        .clk(clk), .rst(rst), .tick_in(tick_in), .restart(presc_wr),
        .div_val(div_q), .trim_val(trim_q), .sec_tick(sec_tick)
    );

    rtc_time_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .cnt_wr(cnt_wr),
        .alarm_wr(alarm_wr), .wdata(reg_wdata), .seconds(seconds),
        .alarm_val(alarm_val), .alarm_hit(alarm_hit)
    );

    rtc_event_ctrl u_evt (
        .clk(clk), .rst(rst), .st_wr(st_wr), .st_wdata(reg_wdata[3:0]),
        .tick_ev(sec_tick), .alarm_ev(alarm_hit), .status(status_q),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_ALARM):   reg_rdata = alarm_val;
            ADDR_W'(OFS_SECONDS): reg_rdata = seconds;
            ADDR_W'(OFS_PRESC):   reg_rdata = DATA_W'({trim_q, div_q});
            ADDR_W'(OFS_STATUS):  reg_rdata = DATA_W'(status_q);
            default:              reg_rdata = '0;
        endcase
    end

    logic unused_presc_w;
    assign unused_presc_w = (PRESC_W > DATA_W);
endmodule

// File: rtl/rtc_seconds_unit_chk.sv
module rtc_seconds_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_in,
    input logic              sec_tick,
    input logic              cnt_wr,
    input logic              alarm_hit,
    input logic [DATA_W-1:0] seconds,
    input logic [3:0]        status_bits,
    input logic              irq_tick,
    input logic              irq_alarm
);
    AST_TICK_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> tick_in); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !cnt_wr) |=> seconds == $past(seconds) + 1'b1); // R6

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !cnt_wr) |=> $stable(seconds)); // R6

    AST_TICK_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> status_bits[1]); // R7

    AST_ALARM_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> status_bits[0]); // R8

    AST_IRQ_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_tick |-> (status_bits[3] && status_bits[1])); // R10

    AST_IRQ_ALARM_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> (status_bits[2] && status_bits[0])); // R10
endmodule

bind rtc_seconds_unit rtc_seconds_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sec_tick(sec_tick),
    .cnt_wr(cnt_wr), .alarm_hit(alarm_hit), .seconds(seconds),
    .status_bits(status_q), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
);

// File: tb/rtc_seconds_unit_tb.sv
module rtc_seconds_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_tick, irq_alarm;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    localparam logic [4:0] A_ALM = 5'h00, A_SEC = 5'h04, A_PRE = 5'h08, A_ST = 5'h10;

    rtc_seconds_unit u_dut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_in = 1'b1;
            repeat (n) @(negedge clk);
            tick_in = 1'b0;
        end
    endtask

    task automatic chk_sec(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(A_SEC, v);
        chk(req, v, exp);
    endtask

    task automatic chk_st(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(A_ST, v);
        chk(req, v, exp);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(A_ALM, v); chk("R1 alarm", v, 0);
        rd(A_SEC, v); chk("R1 seconds", v, 0);
        rd(A_PRE, v); chk("R1 prescaler", v, 0);
        rd(A_ST, v);  chk("R1 status", v, 0);
        chk("R1 irqs", {30'd0, irq_tick, irq_alarm}, 0);

        // R2: readback layout and unmapped offset
        wr(A_PRE, 32'h0155_0003);
        rd(A_PRE, v); chk("R2 prescaler readback", v, 32'h0155_0003);
        wr(A_PRE, 32'hFFFF_FFFF);
        rd(A_PRE, v); chk("R2 prescaler masked", v, 32'h03FF_FFFF);
        wr(5'h0C, 32'h1234_5678);
        rd(5'h0C, v); chk("R2 unmapped", v, 0);
        wr(A_ALM, 32'hA5A5_0001);
        rd(A_ALM, v); chk("R2 alarm readback", v, 32'hA5A5_0001);

        // R3: divisor sweep, period = d+1 ticks
        for (int d = 1; d <= 6; d++) begin
            wr(A_PRE, d);
            wr(A_SEC, 0);
            ticks(5 * (d + 1) - 1);
            chk_sec($sformatf("R3 div %0d before", d), 4);
            ticks(1);
            chk_sec($sformatf("R3 div %0d at", d), 5);
        end
        repeat (50) @(negedge clk);
        chk_sec("R3 no tick_in no count", 5);

        // R4: divisor zero means 32768 ticks
        wr(A_PRE, 0);
        wr(A_SEC, 0);
        ticks(32767);
        chk_sec("R4 default before", 0);
        ticks(1);
        chk_sec("R4 default at", 1);

        // R5: correction of 2 ticks every 1024th second, divisor 3
        wr(A_PRE, (2 << 16) | 3);
        wr(A_SEC, 0);
        ticks(1023 * 4);
        chk_sec("R5 before corrected second", 1023);
        ticks(1);
        chk_sec("R5 corrected mid", 1023);
        ticks(1);
        chk_sec("R5 corrected end", 1024);
        ticks(3);
        chk_sec("R5 normal again before", 1024);
        ticks(1);
        chk_sec("R5 normal again at", 1025);
        wr(A_PRE, (9 << 16) | 3);
        wr(A_SEC, 0);
        ticks(1023 * 4);
        chk_sec("R5 clamp before", 1023);
        ticks(1);
        chk_sec("R5 clamp one tick", 1024);

        // R6: wrap and write priority
        wr(A_PRE, 1);
        wr(A_SEC, 32'hFFFF_FFFE);
        chk_sec("R6 write readback", 32'hFFFF_FFFE);
        ticks(2);
        chk_sec("R6 step", 32'hFFFF_FFFF);
        ticks(2);
        chk_sec("R6 wrap", 0);
        wr(A_PRE, 1);
        ticks(1);
        tick_in = 1'b1;
        wr(A_SEC, 100);
        tick_in = 1'b0;
        chk_sec("R6 write beats increment", 100);

        // R7 / R10 / R9: second flag, enable gating, clear rules
        wr(A_ST, 32'h3);
        chk_st("R9 clear all", 0);
        wr(A_PRE, 1);
        ticks(1);
        chk_st("R7 flag not yet", 0);
        ticks(1);
        chk_st("R7 flag set", 32'h2);
        chk("R10 irq_tick masked", irq_tick, 0);
        wr(A_ST, 32'h8);
        chk_st("R9 zero keeps flag", 32'hA);
        chk("R10 irq_tick on", irq_tick, 1);
        wr(A_ST, 32'hA);
        chk_st("R9 one clears flag", 32'h8);
        chk("R10 irq_tick off", irq_tick, 0);

        // R8 / R10: alarm
        wr(A_ST, 32'h3);
        wr(A_ALM, 7);
        wr(A_SEC, 5);
        chk_st("R8 no match on 5", 0);
        wr(A_PRE, 1);
        ticks(2);
        wr(A_ST, 32'h2);
        chk_st("R8 no match on 6", 0);
        ticks(2);
        rd(A_ST, v); chk("R8 match by increment", v & 32'h1, 1);
        chk("R10 irq_alarm masked", irq_alarm, 0);
        wr(A_ST, 32'h6);
        chk("R10 irq_alarm on", irq_alarm, 1);
        wr(A_ST, 32'h7);
        chk("R10 irq_alarm off", irq_alarm, 0);
        repeat (20) @(negedge clk);
        chk_st("R8 no repeat while equal", 32'h4);
        wr(A_ALM, 7);
        chk_st("R8 alarm write no set", 32'h4);
        wr(A_SEC, 7);
        chk_st("R8 match by write", 32'h5);
        chk("R10 irq_alarm by write", irq_alarm, 1);

        // R9: event beats clear in the same cycle
        wr(A_PRE, 1);
        ticks(1);
        tick_in = 1'b1;
        wr(A_ST, 32'h3);
        tick_in = 1'b0;
        chk_st("R9 set beats clear", 32'h2);
        chk_sec("R9 second advanced", 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule